// File: doc/BRIEF.md
# AT Command Autobaud Sequencer

This block is the control layer of a serial receiver that learns its line settings from the user's own typing. A start-bit timer in front of it measures the rate of each character that arrives while it is hunting. A bit sampler hands it the bits that follow each start bit, least significant first. The sequencer assembles these into characters and learns the word length and parity from the trailing bits of an "A" or "a". It recognizes the two-character prefixes "AT", "at", "A/" and "a/", and it decides which characters reach the receive buffer. It also publishes the learned configuration and raises an interrupt for the host.

Once the first seven bits of a hunted character are in, the sequencer asks the rate timer to measure again, because a user may type several "A"s before the "T". After an "AT" or "at" it passes through every following character until a carriage return, then goes back to hunting. "A/" and "a/" are a repeat request: the pair is forwarded and nothing is re-learned.

Received characters leave on a valid/ready stream through a small queue. `wr_valid` stays high and `wr_data` stays fixed until a cycle with `wr_ready` high takes the byte. Characters arrive at line rate, so the consumer must drain the queue within a few character times. A character that finds no free slot is dropped. The flow of characters is never stalled.

Top module: `at_autobaud_seq`

## Requirements
- R1: While `mode_sel` is not 2, the sequencer holds itself in the hunting state: no stream writes, no `irq` and no `rate_rearm`, and any half-received prefix is forgotten.
- R2: For every hunted character, `rate_rearm` pulses for exactly one cycle after the clock edge that takes its seventh bit.
- R3: Bits of a character are numbered from 0 in arrival order, with bits 0 to 6 being the 7-bit code. When that code is 41h or 61h, bits 7 and 8 set the format. If bit 7 is 1, the word is 7 bits with parity: even when bits 0 to 7 hold an even number of ones, odd otherwise. If bits 7 and 8 are 0 and 1, the word is 8 bits with no parity. If both are 0, the word is 8 bits with space parity.
- R4: A learned "A" followed by "T" (54h), or "a" followed by "t" (74h), writes the two characters in that order. It loads `status` with parity in [6:5], length in [4] (1 = 8 bits) and the first character's rate code in [3:0]. It pulses `irq` once. Parity codes are 00 none, 01 space, 10 even, 11 odd.
- R5: After a recognized "AT"/"at", each following character is written and pulses `irq`. Its data bits come first, 7 bits being zero-extended to a byte, and the bits after the data are ignored. Once 0Dh has been written, the sequencer hunts again, and later characters are not written.
- R6: A learned "A" or "a" followed by "/" (2Fh) writes the pair and returns to hunting, with no `irq` and no change to `status`.
- R7: A second character that matches none of these, including a mixed-case pair such as "aT" and a line break (all-zero code), discards the prefix and writes nothing. A new "A"/"a" replaces the earlier one, with its own rate and format.
- R8: A start bit reported with `frm_rate_ok` low discards any learned prefix.
- R9: `wr_valid` with `wr_data` held stable until `wr_ready` takes it; the queue keeps QDEPTH bytes in order, and a byte that finds it full is dropped.
- R10: `det_len8` and `det_par` follow `status`, and a 7-bit length is never reported together with space parity.
- R11: After reset, `wr_valid`, `irq`, `rate_rearm` and `status` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Receiver mode; 2 enables the sequencer |
| frm_start | input | 1 | One-cycle pulse when a start bit is seen |
| frm_rate_ok | input | 1 | Rate timer found the start bit inside a valid range |
| frm_rate | input | 4 | Rate code measured for this start bit |
| bit_vld | input | 1 | One-cycle strobe for a sampled bit after the start bit |
| bit_dat | input | 1 | Value of the sampled bit |
| rate_rearm | output | 1 | Pulse asking the rate timer to measure again |
| wr_valid | output | 1 | Stream byte available |
| wr_ready | input | 1 | Consumer accepts the byte this cycle |
| wr_data | output | 8 | Stream byte |
| status | output | 7 | Learned parity, length and rate |
| det_len8 | output | 1 | Learned length is 8 bits |
| det_par | output | 2 | Learned parity code |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every result is due after the clock edge that takes the deciding bit. For a prefix this is the seventh bit of the second character, for the format the ninth bit of the first character, and for a passed-through character its last data bit. At that edge the queue write, `status`, `irq` and `rate_rearm` all update. The bench drives inputs and samples outputs on falling edges, so every registered result is seen half a cycle after it is due. Stream bytes are recorded on each falling edge where valid and ready are both high. Idle cycles follow each stimulus so the queue drains before the recorded bytes, the `irq` and `rate_rearm` pulse counts, and `status` are compared with the values expected for that stimulus.

// File: rtl/at_seq_pkg.sv
package at_seq_pkg;
  localparam int FRAME_BITS = 9;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int RATE_W     = 4;
  localparam int STAT_W     = RATE_W + 3;
  localparam int BYTE_W     = 8;

  localparam logic [2:0] MODE_AUTOBAUD = 3'd2;

  localparam logic [6:0] CH_UP_A  = 7'h41;
  localparam logic [6:0] CH_LO_A  = 7'h61;
  localparam logic [6:0] CH_UP_T  = 7'h54;
  localparam logic [6:0] CH_LO_T  = 7'h74;
  localparam logic [6:0] CH_SLASH = 7'h2F;
  localparam logic [7:0] CH_CR    = 8'h0D;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_SPACE = 2'b01,
    PAR_EVEN  = 2'b10,
    PAR_ODD   = 2'b11
  } par_e;

  typedef enum logic [2:0] {
    S_HUNT,
    S_CHR7,
    S_FMT,
    S_SKIP,
    S_CMD_GAP,
    S_CMD_BITS
  } seq_st_e;
endpackage

// File: rtl/at_bit_collect.sv
module at_bit_collect
  import at_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  bit_vld,
  input  logic                  bit_dat,
  output logic [FRAME_BITS-1:0] bits_nx,
  output logic [CNT_W-1:0]      bcnt
);
  logic [FRAME_BITS-1:0] bits_q;
  logic                  room;

  assign room = (bcnt < CNT_W'(FRAME_BITS));

  // Current frame including the bit arriving this cycle.
  always_comb begin
    bits_nx = bits_q;
    if (bit_vld && room) bits_nx[bcnt] = bit_dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      bcnt   <= '0;
    end else if (clr) begin
      bits_q <= '0;
      bcnt   <= '0;
    end else if (bit_vld && room) begin
      bits_q <= bits_nx;
      bcnt   <= bcnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/at_fmt_decode.sv
module at_fmt_decode
  import at_seq_pkg::*;
(
  input  logic [6:0] code7,
  input  logic       tail0,
  input  logic       tail1,
  output logic       len8,
  output par_e       par
);
  // tail0 is either the parity bit of a 7-bit word or the top data bit of
  // an 8-bit word (always 0 for the letter A); tail1 follows it.
  always_comb begin
    if (tail0) begin
      len8 = 1'b0;
      par  = (^{code7, tail0}) ? PAR_ODD : PAR_EVEN;
    end else if (tail1) begin
      len8 = 1'b1;
      par  = PAR_NONE;
    end else begin
      len8 = 1'b1;
      par  = PAR_SPACE;
    end
  end
endmodule

// File: rtl/at_wr_queue.sv
module at_wr_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,
  input  logic [DW-1:0] dat_a,
  input  logic          push_b,
  input  logic [DW-1:0] dat_b,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp, wp_b;
  logic [CW-1:0] cnt, free;
  logic          take_a, take_b, pop;

  assign free      = DEPTH_C - cnt;
  assign take_a    = push_a && (free >= CW'(1));
  assign take_b    = push_b && (free >= (take_a ? CW'(2) : CW'(1)));
  assign pop       = out_valid && out_ready;
  assign wp_b      = take_a ? wp + AW'(1) : wp;
  assign out_valid = (cnt != '0);
  assign out_data  = out_valid ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (take_a) mem[wp]   <= dat_a;
    if (take_b) mem[wp_b] <= dat_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + AW'(take_a) + AW'(take_b);
      rp  <= rp + AW'(pop);
      cnt <= cnt + CW'(take_a) + CW'(take_b) - CW'(pop);
    end
  end
endmodule

// File: rtl/at_autobaud_seq.sv
module at_autobaud_seq
  import at_seq_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              frm_start,
  input  logic              frm_rate_ok,
  input  logic [RATE_W-1:0] frm_rate,
  input  logic              bit_vld,
  input  logic              bit_dat,
  output logic              rate_rearm,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [BYTE_W-1:0] wr_data,
  output logic [STAT_W-1:0] status,
  output logic              det_len8,
  output logic [1:0]        det_par,
  output logic              irq
);
  localparam logic [CNT_W-1:0] IDX_CODE_END = CNT_W'(6);
  localparam logic [CNT_W-1:0] IDX_FMT_END  = CNT_W'(8);
  localparam logic [CNT_W-1:0] IDX_LEN8_END = CNT_W'(7);

  seq_st_e               st_q, st_d;
  logic                  active;
  logic [FRAME_BITS-1:0] bits_nx;
  logic [CNT_W-1:0]      bcnt;
  logic [6:0]            code7;
  logic                  dec_len8;
  par_e                  dec_par;

  logic [RATE_W-1:0] rate_q, rate_d, prate_q, prate_d;
  logic              plen8_q, plen8_d;
  logic [1:0]        ppar_q, ppar_d;
  logic              have_q, have_d;
  logic [6:0]        first_q, first_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              irq_d, rearm_d;
  logic              push_a, push_b;
  logic [BYTE_W-1:0] dat_a, dat_b, cmd_byte;
  logic [CNT_W-1:0]  cmd_last;
  logic              t_match;

  assign active = (mode_sel == MODE_AUTOBAUD);

  at_bit_collect u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (frm_start),
    .bit_vld (bit_vld && active),
    .bit_dat (bit_dat),
    .bits_nx (bits_nx),
    .bcnt    (bcnt)
  );

  assign code7 = bits_nx[6:0];

  at_fmt_decode u_fmt (
    .code7 (code7),
    .tail0 (bits_nx[7]),
    .tail1 (bits_nx[8]),
    .len8  (dec_len8),
    .par   (dec_par)
  );

  assign t_match  = (first_q == CH_UP_A) ? (code7 == CH_UP_T) : (code7 == CH_LO_T);
  assign cmd_last = stat_q[RATE_W] ? IDX_LEN8_END : IDX_CODE_END;
  assign cmd_byte = stat_q[RATE_W] ? bits_nx[7:0] : {1'b0, bits_nx[6:0]};

  always_comb begin
    st_d    = st_q;
    rate_d  = rate_q;
    prate_d = prate_q;
    plen8_d = plen8_q;
    ppar_d  = ppar_q;
    have_d  = have_q;
    first_d = first_q;
    stat_d  = stat_q;
    irq_d   = 1'b0;
    rearm_d = 1'b0;
    push_a  = 1'b0;
    push_b  = 1'b0;
    dat_a   = '0;
    dat_b   = '0;
    if (!active) begin
      st_d   = S_HUNT;
      have_d = 1'b0;
    end else if (frm_start) begin
      if (st_q == S_CMD_GAP || st_q == S_CMD_BITS) begin
        st_d = S_CMD_BITS;
      end else if (frm_rate_ok) begin
        st_d   = S_CHR7;
        rate_d = frm_rate;
      end else begin
        st_d   = S_HUNT;
        have_d = 1'b0;
      end
    end else if (bit_vld) begin
      unique case (st_q)
        S_CHR7: begin
          if (bcnt == IDX_CODE_END) begin
            rearm_d = 1'b1;
            have_d  = 1'b0;
            st_d    = S_SKIP;
            if (code7 == CH_UP_A || code7 == CH_LO_A) begin
              first_d = code7;
              st_d    = S_FMT;
            end else if (have_q && t_match) begin
              push_a = 1'b1;
              dat_a  = {1'b0, first_q};
              push_b = 1'b1;
              dat_b  = {1'b0, code7};
              stat_d = {ppar_q, plen8_q, prate_q};
              irq_d  = 1'b1;
              st_d   = S_CMD_GAP;
            end else if (have_q && code7 == CH_SLASH) begin
              push_a = 1'b1;
              dat_a  = {1'b0, first_q};
              push_b = 1'b1;
              dat_b  = {1'b0, code7};
            end
          end
        end
        S_FMT: begin
          if (bcnt == IDX_FMT_END) begin
            plen8_d = dec_len8;
            ppar_d  = dec_par;
            prate_d = rate_q;
            have_d  = 1'b1;
            st_d    = S_SKIP;
          end
        end
        S_CMD_BITS: begin
          if (bcnt == cmd_last) begin
            push_a = 1'b1;
            dat_a  = cmd_byte;
            irq_d  = 1'b1;
            st_d   = (cmd_byte == CH_CR) ? S_HUNT : S_CMD_GAP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_HUNT;
      rate_q     <= '0;
      prate_q    <= '0;
      plen8_q    <= 1'b0;
      ppar_q     <= PAR_NONE;
      have_q     <= 1'b0;
      first_q    <= '0;
      stat_q     <= '0;
      irq        <= 1'b0;
      rate_rearm <= 1'b0;
    end else begin
      st_q       <= st_d;
      rate_q     <= rate_d;
      prate_q    <= prate_d;
      plen8_q    <= plen8_d;
      ppar_q     <= ppar_d;
      have_q     <= have_d;
      first_q    <= first_d;
      stat_q     <= stat_d;
      irq        <= irq_d;
      rate_rearm <= rearm_d;
    end
  end

  at_wr_queue #(.DW(BYTE_W), .DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_a    (push_a),
    .dat_a     (dat_a),
    .push_b    (push_b),
    .dat_b     (dat_b),
    .out_valid (wr_valid),
    .out_data  (wr_data),
    .out_ready (wr_ready)
  );

  assign status   = stat_q;
  assign det_len8 = stat_q[RATE_W];
  assign det_par  = stat_q[RATE_W+2:RATE_W+1];
endmodule

// File: rtl/at_autobaud_seq_chk.sv
module at_autobaud_seq_chk
  import at_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_sel,
  input logic              rate_rearm,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [BYTE_W-1:0] wr_data,
  input logic [STAT_W-1:0] status,
  input logic              det_len8,
  input logic [1:0]        det_par,
  input logic              irq
);
  // R1
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MODE_AUTOBAUD) |=> (!irq && !rate_rearm));

  // R2
  rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_rearm |=> !rate_rearm);

  // R4
  status_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> irq);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  // R10
  no_7space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_len8 |-> (det_par != 2'b01));
endmodule

bind at_autobaud_seq at_autobaud_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .rate_rearm (rate_rearm),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_data    (wr_data),
  .status     (status),
  .det_len8   (det_len8),
  .det_par    (det_par),
  .irq        (irq)
);

// File: tb/at_autobaud_seq_tb_top.sv
`timescale 1ns/1ps
module at_autobaud_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'd2;
  logic       frm_start = 1'b0;
  logic       frm_rate_ok = 1'b0;
  logic [3:0] frm_rate = '0;
  logic       bit_vld = 1'b0;
  logic       bit_dat = 1'b0;
  logic       rate_rearm, wr_valid, det_len8, irq;
  logic       wr_ready = 1'b1;
  logic [7:0] wr_data;
  logic [6:0] status;
  logic [1:0] det_par;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int gcnt   = 0;
  int irq_cnt = 0;
  int rearm_cnt = 0;
  logic [7:0] got [64];

  always #10 clk = ~clk;

  at_autobaud_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .frm_start(frm_start),
    .frm_rate_ok(frm_rate_ok), .frm_rate(frm_rate), .bit_vld(bit_vld),
    .bit_dat(bit_dat), .rate_rearm(rate_rearm), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .status(status),
    .det_len8(det_len8), .det_par(det_par), .irq(irq)
  );

  // Fields: code1[28:22] tail0[21] tail1[20] code2[19:13] rate[12:9] kind[8:7] stat[6:0]
  // kind: 0 nothing written, 1 command prefix, 2 repeat prefix
  localparam logic [28:0] VEC [8] = '{
    {7'h41, 1'b0, 1'b1, 7'h54, 4'd3, 2'd1, 7'h13},
    {7'h61, 1'b1, 1'b1, 7'h74, 4'd5, 2'd1, 7'h45},
    {7'h41, 1'b1, 1'b1, 7'h2F, 4'd9, 2'd2, 7'h00},
    {7'h61, 1'b0, 1'b0, 7'h54, 4'd2, 2'd0, 7'h00},
    {7'h41, 1'b0, 1'b0, 7'h54, 4'd1, 2'd1, 7'h31},
    {7'h00, 1'b0, 1'b0, 7'h54, 4'd6, 2'd0, 7'h00},
    {7'h61, 1'b0, 1'b1, 7'h2F, 4'd7, 2'd2, 7'h00},
    {7'h41, 1'b0, 1'b1, 7'h74, 4'd8, 2'd0, 7'h00}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready && gcnt < 64) begin
        got[gcnt] = wr_data;
        gcnt++;
      end
      if (irq) irq_cnt++;
      if (rate_rearm) rearm_cnt++;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Compare n bytes recorded from index base; expected byte k is exp[8k+:8].
  task automatic chk_bytes(input string req, input int base, input logic [31:0] exp, input int n);
    chk({req, " count"}, gcnt - base, n);
    for (int k = 0; k < n; k++)
      if (base + k < gcnt) chk({req, " byte"}, got[base+k], exp[8*k +: 8]);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send_frame(input logic ok, input logic [3:0] rate,
                            input logic [9:0] w, input int n);
    @(negedge clk);
    frm_start = 1'b1; frm_rate_ok = ok; frm_rate = rate;
    @(negedge clk);
    frm_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit_dat = w[i]; bit_vld = 1'b1;
      @(negedge clk);
      bit_vld = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic send_first(input logic [3:0] rate, input logic [6:0] c, input logic t0, input logic t1);
    send_frame(1'b1, rate, {1'b1, t1, t0, c}, 9);
  endtask

  task automatic send_second(input logic [3:0] rate, input logic [6:0] c);
    send_frame(1'b1, rate, {2'b11, 1'b0, c}, 9);
  endtask

  task automatic send_cmd(input logic [7:0] d, input logic len8);
    if (len8) send_frame(1'b1, 4'd0, {2'b11, d}, 10);
    else      send_frame(1'b1, 4'd0, {2'b11, 1'b0, d[6:0]}, 9);
  endtask

  task automatic set_ready(input logic r);
    @(posedge clk); #1 wr_ready = r;
  endtask

  initial begin
    logic [6:0] exp_stat;
    int g0, i0, r0;
    idle(3);
    // R11: reset state
    chk("R11 wr_valid", wr_valid, 0);
    chk("R11 irq", irq, 0);
    chk("R11 rate_rearm", rate_rearm, 0);
    chk("R11 status", status, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    exp_stat = '0;

    for (int v = 0; v < 8; v++) begin
      logic [28:0] e;
      e = VEC[v];
      g0 = gcnt; i0 = irq_cnt; r0 = rearm_cnt;
      send_first(e[12:9], e[28:22], e[21], e[20]);
      send_second(4'd0, e[19:13]);
      if (e[8:7] == 2'd1) begin
        exp_stat = e[6:0];
        send_cmd(8'h0D, e[4]);
      end
      idle(6);
      // R2: one rearm per hunted character
      chk("R2 rearm count", rearm_cnt - r0, 2);
      if (e[8:7] == 2'd1) begin
        // R4 R5 R3: prefix pair, carriage return, learned status
        chk_bytes("R4 command prefix", g0, {8'h00, 8'h0D, 1'b0, e[19:13], 1'b0, e[28:22]}, 3);
        chk("R4 irq count", irq_cnt - i0, 2);
      end else if (e[8:7] == 2'd2) begin
        // R6: repeat pair, no irq
        chk_bytes("R6 repeat prefix", g0, {16'h0, 1'b0, e[19:13], 1'b0, e[28:22]}, 2);
        chk("R6 irq count", irq_cnt - i0, 0);
      end else begin
        // R7: mismatch or break discards
        chk_bytes("R7 discard", g0, 32'h0, 0);
        chk("R7 irq count", irq_cnt - i0, 0);
      end
      chk("R3 status", status, exp_stat);
      // R10
      chk("R10 len port", det_len8, exp_stat[4]);
      chk("R10 par port", det_par, exp_stat[6:5]);
    end

    // R1: mode not selected
    g0 = gcnt; i0 = irq_cnt; r0 = rearm_cnt;
    @(negedge clk) mode_sel = 3'd0;
    send_first(4'd3, 7'h41, 1'b0, 1'b1);
    send_second(4'd0, 7'h54);
    idle(4);
    chk_bytes("R1 mode off", g0, 32'h0, 0);
    chk("R1 irq", irq_cnt - i0, 0);
    chk("R1 rearm", rearm_cnt - r0, 0);
    chk("R1 status", status, exp_stat);
    @(negedge clk) mode_sel = 3'd2;

    // R8: failed rate measurement drops the learned A
    g0 = gcnt;
    send_first(4'd3, 7'h41, 1'b0, 1'b1);
    send_frame(1'b0, 4'd0, 10'h3FF, 0);
    send_second(4'd0, 7'h54);
    idle(4);
    chk_bytes("R8 rate fail", g0, 32'h0, 0);

    // R7: repeated A, second one wins (7-bit even, rate 4)
    g0 = gcnt; i0 = irq_cnt;
    send_first(4'd2, 7'h41, 1'b0, 1'b1);
    send_first(4'd4, 7'h61, 1'b1, 1'b1);
    send_second(4'd0, 7'h74);
    send_cmd(8'h4B, 1'b0);
    send_cmd(8'h0D, 1'b0);
    idle(6);
    chk_bytes("R7 repeated A", g0, 32'h0D4B7461, 4);
    chk("R7 status", status, 7'h44);
    chk("R5 irq per char", irq_cnt - i0, 3);

    // R5: 8-bit pass-through, then hunting again after CR
    g0 = gcnt; i0 = irq_cnt;
    send_first(4'd3, 7'h41, 1'b0, 1'b1);
    send_second(4'd0, 7'h54);
    send_cmd(8'h8A, 1'b1);
    send_cmd(8'h0D, 1'b1);
    send_frame(1'b1, 4'd3, {2'b11, 8'h55}, 10);
    idle(6);
    chk_bytes("R5 pass-through", g0, 32'h0D8A5441, 4);
    chk("R5 irq", irq_cnt - i0, 3);

    // R9: back-pressure, hold and drop when full
    g0 = gcnt; i0 = irq_cnt;
    set_ready(1'b0);
    send_first(4'd3, 7'h41, 1'b0, 1'b1);
    send_second(4'd0, 7'h54);
    send_cmd(8'h42, 1'b1);
    send_cmd(8'h43, 1'b1);
    send_cmd(8'h44, 1'b1);
    send_cmd(8'h0D, 1'b1);
    idle(3);
    chk("R9 valid held", wr_valid, 1);
    chk("R9 data held", wr_data, 8'h41);
    chk("R9 irq", irq_cnt - i0, 5);
    set_ready(1'b1);
    idle(8);
    chk_bytes("R9 drained", g0, 32'h43425441, 4);

    report();
  end
endmodule